// File: doc/BRIEF.md
# Randomized Dummy Instruction Inserter

This block sits between instruction fetch and decode. It passes fetched instructions through a valid/ready handshake. While insertion is enabled, it places a harmless dummy instruction into the stream after a pseudo-random number of real instructions. The dummies blur the timing and power profile of the executed code without changing any architectural state. A flag travels with every output instruction so that later stages can tell dummies from real ones.

A 32-bit Galois LFSR sets the number of real instructions between two dummies. A 3-bit mask bounds that number. The LFSR also picks the operation and source registers of each dummy. Software can reseed the LFSR at any time through a seed value and a write strobe.

Top module: `dummy_insert_unit`

## Requirements
- R1: Reset is synchronous and active-high. It clears the real-instruction counter and the gap limit to 0 and loads the LFSR with 32'h5EED_C0DE. As a result, the first output after enabling is a dummy built from that value.
- R2: While `ctl_en_i` is 0, no dummy is produced. The outputs follow the inputs: `dn_valid_o = up_valid_i`, `dn_instr_o = up_instr_i` and `up_ready_o = dn_ready_i`.
- R3: Real instructions leave unchanged and in arrival order. While a dummy is presented, `up_ready_o` is 0, so no real instruction is taken or lost.
- R4: Each time a dummy is accepted, the limit reloads to the low 5 bits of the LFSR's next state ANDed with `{ctl_mask_i, 2'b11}`. The next dummy is presented once exactly that many real instructions have been accepted.
- R5: The gap between dummies never exceeds `{mask,2'b11}`: at most 3, 7, 15 or 31 real instructions for masks 000, 001, 011 and 111. Any other mask value, for example 010, also works under the same bound.
- R6: The LFSR moves one step only when a dummy is accepted. A step shifts right, and if the bit shifted out is 1, it XORs the result with 32'h8020_0003. The state is never zero.
- R7: A seed write loads the LFSR with `seed_data_i`. A zero seed loads 32'h5EED_C0DE instead.
- R8: If a seed write and a dummy acceptance happen in the same cycle, the LFSR takes the seed. The limit still reloads from the step of the old state.
- R9: A dummy is an R-type register operation: opcode 7'b0110011, rd = x0, funct7 = 0, rs1 = LFSR[9:5], rs2 = LFSR[14:10]. LFSR[16:15] selects funct3: 0 is ADD (000), 1 is OR (110), 2 is AND (111), 3 is XOR (100).
- R10: Clearing `ctl_en_i` resets the real-instruction count to 0. The limit and the LFSR are kept.
- R11: A presented dummy stays valid with a stable encoding until `dn_ready_i` accepts it, unless the LFSR is reseeded or insertion is disabled in the meantime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ctl_en_i | input | 1 | Insertion enable |
| ctl_mask_i | input | 3 | Gap bound mask |
| seed_data_i | input | 32 | New LFSR seed |
| seed_we_i | input | 1 | Seed write strobe |
| up_valid_i | input | 1 | Fetched instruction valid |
| up_instr_i | input | 32 | Fetched instruction |
| up_ready_o | output | 1 | Fetched instruction accepted |
| dn_valid_o | output | 1 | Output instruction valid |
| dn_instr_o | output | 32 | Output instruction |
| dn_dummy_o | output | 1 | Output instruction is a dummy |
| dn_ready_i | input | 1 | Decode ready |

## Verification
A reseed and a dummy acceptance can fall in the same cycle. When they do, two updates of the LFSR compete, and the limit must still come from the old state. The bench forces decode ready high, waits until a dummy is on the output, and then pulses the seed strobe so that both events land on the same edge. The reference model encodes R8, so the next gap must equal the old step's bits and the following dummy must carry fields taken from the written seed.

// File: rtl/dii_pkg.sv
package dii_pkg;

    localparam int XLEN         = 32;
    localparam int LFSR_W       = 32;
    localparam int MASK_W       = 3;
    localparam int LIM_W        = MASK_W + 2;
    localparam logic [LFSR_W-1:0] LFSR_TAPS    = 32'h8020_0003;
    localparam logic [LFSR_W-1:0] SEED_DEFAULT = 32'h5EED_C0DE;
    localparam logic [6:0] OPC_REG_OP = 7'b0110011;
    localparam int PICK_LSB     = 5;

    typedef enum logic [1:0] {
        SEL_ADD = 2'd0,
        SEL_OR  = 2'd1,
        SEL_AND = 2'd2,
        SEL_XOR = 2'd3
    } alu_sel_e;

    typedef struct packed {
        alu_sel_e    op;
        logic [4:0]  rs2;
        logic [4:0]  rs1;
    } dummy_pick_t;

    localparam int PICK_W = $bits(dummy_pick_t);

    typedef struct packed {
        logic [6:0] funct7;
        logic [4:0] rs2;
        logic [4:0] rs1;
        logic [2:0] funct3;
        logic [4:0] rd;
        logic [6:0] opcode;
    } rtype_t;

    function automatic logic [2:0] funct3_of(alu_sel_e sel);
        case (sel)
            SEL_ADD: return 3'b000;
            SEL_OR:  return 3'b110;
            SEL_AND: return 3'b111;
            default: return 3'b100;
        endcase
    endfunction

    function automatic logic [LIM_W-1:0] bound_of(logic [MASK_W-1:0] mask);
        return {mask, 2'b11};
    endfunction

endpackage

// File: rtl/dii_lfsr.sv
module dii_lfsr
    import dii_pkg::*;
#(
    parameter int              W        = LFSR_W,
    parameter logic [W-1:0]    TAPS     = LFSR_TAPS,
    parameter logic [W-1:0]    DEFAULT  = SEED_DEFAULT,
    parameter int              LW       = LIM_W,
    parameter int              PLSB     = PICK_LSB
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              step_i,
    input  logic              seed_we_i,
    input  logic [W-1:0]      seed_i,
    output logic [LW-1:0]     limit_bits_o,
    output dummy_pick_t       pick_o
);

    logic [W-1:0] state_q;
    logic [W-1:0] state_next;

    // Galois right-shift step, one XOR per tap bit
    for (genvar i = 0; i < W; i++) begin : g_step
        if (i == W - 1) begin : g_top
            assign state_next[i] = TAPS[i] & state_q[0];
        end else begin : g_mid
            assign state_next[i] = state_q[i+1] ^ (TAPS[i] & state_q[0]);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= DEFAULT;
        end else if (seed_we_i) begin
            state_q <= (seed_i == '0) ? DEFAULT : seed_i;
        end else if (step_i) begin
            state_q <= state_next;
        end
    end

    assign limit_bits_o = state_next[LW-1:0];
    assign pick_o       = dummy_pick_t'(state_q[PLSB +: PICK_W]);

    AST_SEED_TAKES: assert property (@(posedge clk_i) disable iff (rst_i)
        (seed_we_i && seed_i != '0) |=> state_q == $past(seed_i));          // R7
    AST_ZERO_SEED_SUBST: assert property (@(posedge clk_i) disable iff (rst_i)
        (seed_we_i && seed_i == '0) |=> state_q == DEFAULT);               // R7
    AST_STATE_NONZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        state_q != '0);                                                     // R6
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
        (!step_i && !seed_we_i) |=> $stable(state_q));                      // R6

endmodule

// File: rtl/dii_gap_counter.sv
module dii_gap_counter
    import dii_pkg::*;
#(
    parameter int MW = MASK_W,
    parameter int LW = MW + 2
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          en_i,
    input  logic [MW-1:0] mask_i,
    input  logic          real_fire_i,
    input  logic          dummy_fire_i,
    input  logic [LW-1:0] rand_i,
    output logic          pending_o
);

    logic [LW-1:0] cnt_q;
    logic [LW-1:0] limit_q;
    logic [LW-1:0] bound;

    assign bound = {mask_i, 2'b11};

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q   <= '0;
            limit_q <= '0;
        end else begin
            if (!en_i || dummy_fire_i) begin
                cnt_q <= '0;
            end else if (real_fire_i) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (dummy_fire_i) begin
                limit_q <= rand_i & bound;
            end
        end
    end

    assign pending_o = en_i && (cnt_q >= limit_q);

    AST_CNT_WITHIN_LIMIT: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q <= limit_q);                                                  // R4
    AST_LIMIT_IN_MASK: assert property (@(posedge clk_i) disable iff (rst_i)
        dummy_fire_i |=> (limit_q & ~{$past(mask_i), 2'b11}) == '0);        // R5
    AST_DISABLE_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> cnt_q == '0);                                             // R10
    AST_RESTART_AFTER_DUMMY: assert property (@(posedge clk_i) disable iff (rst_i)
        dummy_fire_i |=> cnt_q == '0);                                      // R4

endmodule

// File: rtl/dii_dummy_gen.sv
module dii_dummy_gen
    import dii_pkg::*;
#(
    parameter int XW = XLEN
) (
    input  dummy_pick_t     pick_i,
    output logic [XW-1:0]   instr_o
);

    rtype_t word;

    always_comb begin
        word.funct7 = 7'd0;
        word.rs2    = pick_i.rs2;
        word.rs1    = pick_i.rs1;
        word.funct3 = funct3_of(pick_i.op);
        word.rd     = 5'd0;
        word.opcode = OPC_REG_OP;
    end

    assign instr_o = XW'(word);

endmodule

// File: rtl/dummy_insert_unit.sv
module dummy_insert_unit
    import dii_pkg::*;
#(
    parameter int XW = XLEN,
    parameter int SW = LFSR_W,
    parameter int MW = MASK_W
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          ctl_en_i,
    input  logic [MW-1:0] ctl_mask_i,
    input  logic [SW-1:0] seed_data_i,
    input  logic          seed_we_i,
    input  logic          up_valid_i,
    input  logic [XW-1:0] up_instr_i,
    output logic          up_ready_o,
    output logic          dn_valid_o,
    output logic [XW-1:0] dn_instr_o,
    output logic          dn_dummy_o,
    input  logic          dn_ready_i
);

    localparam int LW = MW + 2;

    logic          pending;
    logic          dummy_fire;
    logic          real_fire;
    logic [LW-1:0] limit_bits;
    dummy_pick_t   pick;
    logic [XW-1:0] dummy_word;

    assign dummy_fire = pending && dn_ready_i;
    assign real_fire  = !pending && up_valid_i && dn_ready_i;

    dii_lfsr #(
        .W       (SW),
        .TAPS    (SW'(LFSR_TAPS)),
        .DEFAULT (SW'(SEED_DEFAULT)),
        .LW      (LW),
        .PLSB    (PICK_LSB)
    ) u_lfsr (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .step_i       (dummy_fire),
        .seed_we_i    (seed_we_i),
        .seed_i       (seed_data_i),
        .limit_bits_o (limit_bits),
        .pick_o       (pick)
    );

    dii_gap_counter #(
        .MW (MW),
        .LW (LW)
    ) u_gap (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .en_i         (ctl_en_i),
        .mask_i       (ctl_mask_i),
        .real_fire_i  (real_fire),
        .dummy_fire_i (dummy_fire),
        .rand_i       (limit_bits),
        .pending_o    (pending)
    );

    dii_dummy_gen #(
        .XW (XW)
    ) u_gen (
        .pick_i  (pick),
        .instr_o (dummy_word)
    );

    always_comb begin
        if (pending) begin
            dn_valid_o = 1'b1;
            dn_instr_o = dummy_word;
            up_ready_o = 1'b0;
        end else begin
            dn_valid_o = up_valid_i;
            dn_instr_o = up_instr_i;
            up_ready_o = dn_ready_i;
        end
    end
    assign dn_dummy_o = pending;

    AST_UP_BLOCKED: assert property (@(posedge clk_i) disable iff (rst_i)
        dn_dummy_o |-> !up_ready_o);                                        // R3
    AST_NO_DUMMY_OFF: assert property (@(posedge clk_i) disable iff (rst_i)
        !ctl_en_i |-> !dn_dummy_o);                                         // R2
    AST_DUMMY_RD_X0: assert property (@(posedge clk_i) disable iff (rst_i)
        dn_dummy_o |-> (dn_instr_o[11:7] == 5'd0 && dn_instr_o[6:0] == OPC_REG_OP)); // R9
    AST_DUMMY_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
        (dn_dummy_o && !dn_ready_i && !seed_we_i)
        |=> (!ctl_en_i || (dn_dummy_o && $stable(dn_instr_o))));            // R11

endmodule

// File: tb/dummy_insert_unit_test.sv
`timescale 1ns/1ps
module dummy_insert_unit_test;

    localparam logic [31:0] DEF_SEED = 32'h5EED_C0DE;
    localparam logic [31:0] POLY     = 32'h8020_0003;
    localparam logic [31:0] BASE     = 32'h4000_0000;

    logic        clk = 1'b0;
    logic        rst, en, seed_we, up_valid, dn_ready;
    logic [2:0]  mask;
    logic [31:0] seed, up_instr;
    logic        up_ready, dn_valid, dn_dummy;
    logic [31:0] dn_instr;

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int accepted = 0;
    bit force_ready = 0;
    string tag = "R1";
    bit done = 0;

    logic [31:0] m_lfsr;
    int m_cnt, m_limit, m_bound, gap_seen;

    assign up_instr = BASE + 32'(accepted);

    dummy_insert_unit uut (
        .clk_i(clk), .rst_i(rst), .ctl_en_i(en), .ctl_mask_i(mask),
        .seed_data_i(seed), .seed_we_i(seed_we),
        .up_valid_i(up_valid), .up_instr_i(up_instr), .up_ready_o(up_ready),
        .dn_valid_o(dn_valid), .dn_instr_o(dn_instr), .dn_dummy_o(dn_dummy),
        .dn_ready_i(dn_ready)
    );

    function automatic logic [31:0] lstep(logic [31:0] s);
        logic [31:0] r;
        r = s >> 1;
        if (s[0]) r = r ^ POLY;
        return r;
    endfunction

    function automatic logic [31:0] enc(logic [31:0] s);
        logic [2:0] f3;
        case (s[16:15])
            2'd0: f3 = 3'b000;
            2'd1: f3 = 3'b110;
            2'd2: f3 = 3'b111;
            default: f3 = 3'b100;
        endcase
        return {7'd0, s[14:10], s[9:5], f3, 5'd0, 7'b0110011};
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // random handshake, applied just after each rising edge
    always @(posedge clk) begin
        #1;
        up_valid = ($urandom % 4) != 0;
        dn_ready = force_ready ? 1'b1 : (($urandom % 4) != 0);
    end

    // reference model, compared mid-cycle
    always @(negedge clk) begin
        bit pend;
        logic [31:0] nxt;
        if (rst) begin
            m_lfsr = DEF_SEED; m_cnt = 0; m_limit = 0; m_bound = 0; gap_seen = 0;
            chk(dn_dummy == 1'b0 && dn_valid == up_valid, "R1", {31'd0, dn_dummy}, 32'd0);
        end else if (!done) begin
            pend = en && (m_cnt >= m_limit);
            chk(dn_dummy == pend, tag, {31'd0, dn_dummy}, {31'd0, pend});
            chk(dn_valid == (pend || up_valid), tag, {31'd0, dn_valid}, {31'd0, pend || up_valid});
            chk(up_ready == (!pend && dn_ready), "R3", {31'd0, up_ready}, {31'd0, !pend && dn_ready});
            if (pend)
                chk(dn_instr == enc(m_lfsr), "R9", dn_instr, enc(m_lfsr));
            else if (up_valid)
                chk(dn_instr == up_instr, "R3", dn_instr, up_instr);
            nxt = m_lfsr;
            if (pend && dn_ready) begin
                chk(gap_seen == m_limit, "R4", 32'(gap_seen), 32'(m_limit));
                chk(gap_seen <= m_bound, "R5", 32'(gap_seen), 32'(m_bound));
                nxt = lstep(m_lfsr);
                m_limit = int'(nxt[4:0] & {mask, 2'b11});
                m_bound = int'({mask, 2'b11});
                m_cnt = 0; gap_seen = 0;
            end else if (!pend && up_valid && dn_ready) begin
                accepted++;
                if (en) begin m_cnt++; gap_seen++; end
            end
            if (!en) begin m_cnt = 0; gap_seen = 0; end
            if (seed_we) nxt = (seed == 0) ? DEF_SEED : seed;   // R7, R8
            m_lfsr = nxt;
        end
    end

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_dummy_check(logic [31:0] s, string req);
        int guard = 0;
        while (!dn_dummy && guard < 500) begin
            @(negedge clk); guard++;
        end
        #0.1;
        chk(dn_dummy && dn_instr == enc(s), req, dn_instr, enc(s));
    endtask

    task automatic reseed_idle(logic [31:0] s);
        en = 0; cyc(2);
        seed = s; seed_we = 1; cyc(1); seed_we = 0; cyc(1);
        en = 1;
        @(negedge clk);
        wait_dummy_check((s == 0) ? DEF_SEED : s, "R7");
    endtask

    task automatic collide(logic [31:0] s);
        force_ready = 1; cyc(2);
        while (!dn_dummy) begin @(posedge clk); #2; end
        seed = s; seed_we = 1;               // R8: same edge as dummy acceptance
        @(posedge clk); #1; seed_we = 0;
        @(negedge clk);
        wait_dummy_check(s, "R8");
        force_ready = 0;
    endtask

    initial begin
        rst = 1; en = 0; mask = 3'b000; seed = 0; seed_we = 0;
        up_valid = 0; dn_ready = 0;
        cyc(4); rst = 0;
        tag = "R2"; cyc(300);
        tag = "R1"; en = 1;
        @(negedge clk); #0.1;
        chk(dn_dummy && dn_instr == enc(DEF_SEED), "R1", dn_instr, enc(DEF_SEED));
        cyc(1);
        tag = "R4";  cyc(3000);
        tag = "R5";  mask = 3'b001; cyc(3000);
        mask = 3'b011; cyc(3000);
        mask = 3'b111; cyc(4000);
        mask = 3'b010; cyc(2000);
        tag = "R10"; en = 0; cyc(40); en = 1; cyc(500);
        tag = "R7";  mask = 3'b011;
        reseed_idle(32'h1234_5678); cyc(500);
        reseed_idle(32'h0);         cyc(500);
        tag = "R8";  mask = 3'b001;
        collide(32'hCAFE_0001); cyc(200);
        collide(32'h0BAD_F00D); cyc(200);
        tag = "R11"; mask = 3'b111; cyc(3000);
        done = 1;
        @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        finish_run();
    end

endmodule